// File: doc/BRIEF.md
# Stepped Volume with Soft Mute

This block scales a stream of signed audio samples from up to sixteen interleaved channels. Each incoming sample carries a channel number. A shared master attenuation code and that channel's own attenuation code are added together. The sum gives a logarithmic attenuation in steps of 0.375 dB, from 0 dB at code 0 down to -95.625 dB at code 255. The scaled sample leaves the block two clock cycles later, tagged with the same channel number.

A change to any code, or to a channel's mute bit, does not take effect at once. Each channel keeps its own applied code. That code moves one step toward the requested value on each valid sample of that channel. A volume change therefore becomes a ramp of at most 0.375 dB per sample, and no audible click results. A muted channel ramps down to full attenuation and then outputs exactly zero. When the mute bit is cleared, the channel ramps back up.

The gain is built from a right shift by the upper four code bits, since 16 steps make 6 dB. The result is then multiplied by a 16-entry mantissa that the lower four code bits select. The product is rounded and clamped back to the sample width.

Top module: `gainstep_top`

## Requirements
- R1: The requested code for channel n is master_code plus that channel's code (bits [8n+7:8n] of chan_codes), clamped at 255.
- R2: The gain for applied code c is M[c mod 16] / 32768 shifted right by floor(c/16) bits, where M[k] = round(32768 * 10^(-0.375k/20)). Code 0 passes the sample unchanged.
- R3: The scaled result is rounded half toward positive infinity and clamped to the signed SAMPLE_W-bit range.
- R4: On each accepted sample of a channel, that channel's applied code moves one step toward the requested code, or stays put if equal. The sample is scaled with the code after this step.
- R5: The applied code of a channel changes only on its own accepted samples. Other channels and idle cycles leave it untouched.
- R6: mute_bits[n] (zero-based) mutes channel n: its requested code becomes 255. A sample whose stepped code is 255 while muted is output as exactly 0.
- R7: After the mute bit is cleared, the channel ramps down from 255 toward its requested code, one step per sample.
- R8: out_valid, out_chan and out_sample appear exactly two clock cycles after the sample is accepted (in_valid high at a rising edge). out_valid is high only then.
- R9: Synchronous active-high reset sets every applied code to 0 and clears out_valid and out_sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_chan | input | CHAN_W | Channel of the incoming sample |
| in_sample | input | SAMPLE_W | Signed input sample |
| master_code | input | CODE_W | Attenuation code shared by all channels |
| chan_codes | input | NUM_CH*CODE_W | Per-channel attenuation codes, channel n at bits [8n+7:8n] |
| mute_bits | input | NUM_CH | Per-channel mute request, bit n for channel n |
| out_valid | output | 1 | Scaled sample present |
| out_chan | output | CHAN_W | Channel of the scaled sample |
| out_sample | output | SAMPLE_W | Signed scaled sample |

## Verification
The bench builds the block with its defaults: sixteen channels, 24-bit samples and 8-bit codes. With these values a single channel can be ramped through all 256 codes within a few hundred samples. All sixteen shift amounts and all sixteen mantissa entries are therefore reached, including the clamp at 255 and the zero output at the mute floor. The full-scale positive and negative samples also fit the 24-bit width, so the rounding and clamping edges are exercised directly.

// File: rtl/gainstep_pkg.sv
package gainstep_pkg;
    localparam int SAMPLE_W   = 24;
    localparam int CODE_W     = 8;
    localparam int FRAC_STEPS = 16;                   // codes per 6 dB
    localparam int FRAC_W     = $clog2(FRAC_STEPS);
    localparam int SHIFT_W    = CODE_W - FRAC_W;
    localparam int MANT_W     = 16;
    localparam int MANT_FRAC  = 15;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    typedef logic [FRAC_STEPS-1:0][MANT_W-1:0] mant_tab_t;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] smp;
        logic [CODE_W-1:0]          code;
        logic                       zero;
    } gain_job_t;

    // Mantissa k = round(2^MANT_FRAC * 10^(-0.375*k/20))
    function automatic mant_tab_t build_mant();
        mant_tab_t t;
        for (int k = 0; k < FRAC_STEPS; k++) begin
            real g;
            g = (2.0 ** MANT_FRAC) * (10.0 ** (-0.375 * k / 20.0));
            t[k] = MANT_W'($rtoi(g + 0.5));
        end
        return t;
    endfunction

    function automatic logic [CODE_W-1:0] sat_add(input logic [CODE_W-1:0] a,
                                                  input logic [CODE_W-1:0] b);
        logic [CODE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CODE_W] ? CODE_MAX : s[CODE_W-1:0];
    endfunction

    function automatic logic [CODE_W-1:0] step_toward(input logic [CODE_W-1:0] cur,
                                                      input logic [CODE_W-1:0] tgt);
        if (cur < tgt) return cur + CODE_W'(1);
        if (cur > tgt) return cur - CODE_W'(1);
        return cur;
    endfunction

    function automatic logic [SAMPLE_W:0] mag(input logic signed [SAMPLE_W-1:0] v);
        logic signed [SAMPLE_W:0] w;
        w = (SAMPLE_W+1)'(v);
        return (w < 0) ? -w : w;
    endfunction
endpackage

// File: rtl/gs_target.sv
module gs_target
    import gainstep_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CHAN_W = $clog2(NUM_CH)
) (
    input  logic [CODE_W-1:0]        master_code,
    input  logic [NUM_CH*CODE_W-1:0] chan_codes,
    input  logic [NUM_CH-1:0]        mute_bits,
    input  logic [CHAN_W-1:0]        sel,
    output logic [CODE_W-1:0]        target,
    output logic                     muted
);
    logic [NUM_CH-1:0][CODE_W-1:0] want;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_want
        assign want[g] = mute_bits[g] ? CODE_MAX
                                      : sat_add(master_code, chan_codes[g*CODE_W +: CODE_W]);
    end

    assign target = want[sel];
    assign muted  = mute_bits[sel];
endmodule

// File: rtl/gs_code_track.sv
module gs_code_track
    import gainstep_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CHAN_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [CHAN_W-1:0] sel,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] next_code
);
    logic [NUM_CH-1:0][CODE_W-1:0] cur_q;

    assign next_code = step_toward(cur_q[sel], target);

    always_ff @(posedge clk) begin
        if (rst)          cur_q <= '0;
        else if (advance) cur_q[sel] <= next_code;
    end

    // R4: a stored code never moves more than one step per sample
    p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
        advance |=> (cur_q[$past(sel)] == $past(cur_q[sel])) ||
                    (cur_q[$past(sel)] == $past(cur_q[sel]) + CODE_W'(1)) ||
                    (cur_q[$past(sel)] == $past(cur_q[sel]) - CODE_W'(1)));

    // R5: without a sample no code changes
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(cur_q));

    // R6: once at the floor with the floor requested, the code stays there
    p_floor_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (advance && target == CODE_MAX && cur_q[sel] == CODE_MAX) |=> cur_q[$past(sel)] == CODE_MAX);
endmodule

// File: rtl/gs_scale.sv
module gs_scale
    import gainstep_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CHAN_W = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CHAN_W-1:0]          in_chan,
    input  gain_job_t                  in_job,
    output logic                       out_valid,
    output logic [CHAN_W-1:0]          out_chan,
    output logic signed [SAMPLE_W-1:0] out_sample
);
    localparam int PROD_W = SAMPLE_W + MANT_W + 1;
    localparam int AMT_W  = $clog2(MANT_FRAC + (1 << SHIFT_W));
    localparam mant_tab_t MANT = build_mant();
    localparam logic signed [PROD_W-1:0] ONE  = 1;
    localparam logic signed [PROD_W-1:0] S_HI = (ONE <<< (SAMPLE_W-1)) - ONE;
    localparam logic signed [PROD_W-1:0] S_LO = -(ONE <<< (SAMPLE_W-1));

    logic [SHIFT_W-1:0]          sh;
    logic [FRAC_W-1:0]           frac;
    logic [AMT_W-1:0]            amt;
    logic signed [PROD_W-1:0]    prod, biased, shifted;
    logic signed [SAMPLE_W-1:0]  clipped;

    assign sh   = in_job.code[CODE_W-1 -: SHIFT_W];
    assign frac = in_job.code[FRAC_W-1:0];
    assign amt  = AMT_W'(MANT_FRAC) + AMT_W'(sh);

    always_comb begin
        prod    = PROD_W'(in_job.smp) * PROD_W'($signed({1'b0, MANT[frac]}));
        biased  = prod + (ONE <<< (amt - AMT_W'(1)));
        shifted = biased >>> amt;
        if (shifted > S_HI)      clipped = SAMPLE_W'(S_HI);
        else if (shifted < S_LO) clipped = SAMPLE_W'(S_LO);
        else                     clipped = SAMPLE_W'(shifted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_chan   <= '0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chan   <= in_chan;
                out_sample <= in_job.zero ? '0 : clipped;
            end
        end
    end

    // R2: code 0 is unity gain
    p_unity_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_job.code == '0 && !in_job.zero) |=> out_sample == $past(in_job.smp));

    // R3: attenuation never raises the magnitude
    p_no_gain_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_job.zero) |=> mag(out_sample) <= mag($past(in_job.smp)));

    // R6: a sample muted at the floor comes out as zero
    p_mute_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_job.zero) |=> out_sample == '0);
endmodule

// File: rtl/gainstep_top.sv
module gainstep_top
    import gainstep_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CHAN_W = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CHAN_W-1:0]          in_chan,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic [CODE_W-1:0]          master_code,
    input  logic [NUM_CH*CODE_W-1:0]   chan_codes,
    input  logic [NUM_CH-1:0]          mute_bits,
    output logic                       out_valid,
    output logic [CHAN_W-1:0]          out_chan,
    output logic signed [SAMPLE_W-1:0] out_sample
);
    logic [CODE_W-1:0] target, next_code;
    logic              muted;
    logic              s1_valid;
    logic [CHAN_W-1:0] s1_chan;
    gain_job_t         s1_job;

    gs_target #(.NUM_CH(NUM_CH), .CHAN_W(CHAN_W)) u_target (
        .master_code (master_code),
        .chan_codes  (chan_codes),
        .mute_bits   (mute_bits),
        .sel         (in_chan),
        .target      (target),
        .muted       (muted)
    );

    gs_code_track #(.NUM_CH(NUM_CH), .CHAN_W(CHAN_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .advance   (in_valid),
        .sel       (in_chan),
        .target    (target),
        .next_code (next_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_chan  <= '0;
            s1_job   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_chan     <= in_chan;
                s1_job.smp  <= in_sample;
                s1_job.code <= next_code;
                s1_job.zero <= muted && (next_code == CODE_MAX);
            end
        end
    end

    gs_scale #(.NUM_CH(NUM_CH), .CHAN_W(CHAN_W)) u_scale (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (s1_valid),
        .in_chan    (s1_chan),
        .in_job     (s1_job),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_sample (out_sample)
    );

    // R8: accepted sample appears two cycles later with its channel
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 (out_valid && out_chan == $past(in_chan, 2)));

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/gainstep_top_test.sv
module gainstep_top_test;
    localparam int PERIOD = 10;
    localparam int NCH = 16;

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic [3:0]         in_chan;
    logic signed [23:0] in_sample;
    logic [7:0]         master_code;
    logic [NCH*8-1:0]   chan_codes;
    logic [NCH-1:0]     mute_bits;
    logic               out_valid;
    logic [3:0]         out_chan;
    logic signed [23:0] out_sample;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    int mc [NCH];       // model of applied code per channel
    int cc [NCH];       // model of per-channel request codes

    always #(PERIOD/2) clk = ~clk;

    gainstep_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .master_code(master_code), .chan_codes(chan_codes),
        .mute_bits(mute_bits), .out_valid(out_valid), .out_chan(out_chan),
        .out_sample(out_sample)
    );

    task automatic chk(input string req, input longint act, input longint expv);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // R2/R3 expectation from the stated gain law
    function automatic longint expect_scaled(input longint x, input int code);
        longint m, p, r;
        int sh;
        m  = longint'($rtoi(32768.0 * (10.0 ** (-0.375 * (code % 16) / 20.0)) + 0.5));
        sh = code / 16;
        p  = x * m;
        r  = (p + (64'sd1 <<< (14 + sh))) >>> (15 + sh);
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic set_chan(input int ch, input int v);
        cc[ch] = v;
        chan_codes[ch*8 +: 8] = 8'(v);
    endtask

    // One sample through the block, model stepped per R1/R4/R6
    task automatic send(input int ch, input longint x, input string req);
        int tgt;
        longint expv;
        tgt = mute_bits[ch] ? 255 : ((master_code + cc[ch] > 255) ? 255 : master_code + cc[ch]);
        if (mc[ch] < tgt) mc[ch]++;
        else if (mc[ch] > tgt) mc[ch]--;
        expv = (mute_bits[ch] && mc[ch] == 255) ? 0 : expect_scaled(x, mc[ch]);
        @(negedge clk);
        in_valid = 1'b1; in_chan = 4'(ch); in_sample = 24'(x);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " out_valid (R8)"}, out_valid, 1);
        chk({req, " out_chan (R8)"}, out_chan, ch);
        chk(req, out_sample, expv);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_chan = '0; in_sample = '0;
        master_code = '0; chan_codes = '0; mute_bits = '0;
        for (int i = 0; i < NCH; i++) begin mc[i] = 0; cc[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 out_valid after reset", out_valid, 0);
        chk("R9 out_sample after reset", out_sample, 0);
        @(negedge clk);
        chk("R8 idle out_valid", out_valid, 0);
    endtask

    task automatic t_unity();
        send(0, 8388607, "R2 unity max");
        chk("R2 unity max explicit", out_sample, 8388607);
        send(7, -8388608, "R2 unity min");
        chk("R9 code zero after reset", out_sample, -8388608);
        send(15, 12345, "R2 unity ch15");
    endtask

    task automatic t_round();
        set_chan(2, 16);
        for (int i = 0; i < 16; i++) send(2, 1000, "R4 ramp to 16");
        send(2, 1000, "R2 half gain");
        chk("R2 code16 halves", out_sample, 500);
        send(2, 3, "R3 round +1.5");
        chk("R3 +1.5 rounds to 2", out_sample, 2);
        send(2, -3, "R3 round -1.5");
        chk("R3 -1.5 rounds to -1", out_sample, -1);
    endtask

    task automatic t_ramp();
        set_chan(3, 5);
        for (int i = 1; i <= 5; i++) begin
            send(3, 4000000, "R4 ramp step");
            chk("R4 model code", mc[3], i);
        end
        send(4, 777777, "R5 other channel untouched");
        chk("R5 ch4 unity", out_sample, 777777);
        set_chan(3, 2);
        repeat (6) @(negedge clk);
        send(3, 4000000, "R5 one step after idle");
        chk("R5 code after idle", mc[3], 4);
    endtask

    task automatic t_sum_sat();
        master_code = 8'd200;
        set_chan(5, 100);
        for (int i = 0; i < 256; i++) send(5, 8388607, "R1 ramp to clamp");
        chk("R1 clamped code", mc[5], 255);
        send(5, 8388607, "R1 floor scale");
        chk("R1 floor value", out_sample, expect_scaled(8388607, 255));
        master_code = 8'd0;
    endtask

    task automatic t_mute();
        mute_bits[9] = 1'b1;
        for (int i = 0; i < 254; i++) send(9, 8388607, "R6 mute ramp");
        chk("R6 nonzero before floor", (out_sample != 0) ? 1 : 0, 1);
        send(9, 8388607, "R6 reaches floor");
        chk("R6 exact zero", out_sample, 0);
        send(9, -8388608, "R6 stays zero");
        send(8, 5555, "R6 neighbour unmuted");
        chk("R6 ch8 unity", out_sample, 5555);
        mute_bits[9] = 1'b0;
        send(9, 8388607, "R7 first unmuted sample");
        chk("R7 code 254", mc[9], 254);
        send(9, 8388607, "R7 second unmuted sample");
    endtask

    initial begin
        t_reset();
        t_unity();
        t_round();
        t_ramp();
        t_sum_sat();
        t_mute();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule